// File: doc/BRIEF.md
# One-Time-Programmable Fuse Sequencer

This block controls an array of one-time-programmable fuse words behind a small 32-bit register bus. Software selects a word by bank and word index, sets interval lengths in a timing register, and then asks for a sense (read) or a program (write) of that word. The block runs a three-phase sequence for either operation: a relax interval, a strobe interval and a second relax interval. A busy flag stays high for the whole sequence.

Programming is guarded by a 16-bit unlock value that must be placed in the control register before the data write that starts it. The unlock value is wiped when the program sequence ends. A refused request sets a sticky error flag and leaves the fuse array untouched. Programming can only set fuse bits. The fuse storage is modelled inside the block as a register array, and every interval is given directly as a count of clock cycles.

Top module: `otp_seq`

## Requirements
- R1: After reset the control, timing and read-data registers read 0, and every fuse word senses as 0.
- R2: The register index on `bus_addr` selects: 0 control, 1 control-set alias, 2 control-clear alias, 3 timing, 4 read command, 5 read data, 6 write data. The control register holds the unlock value in bits 31:16, the error flag in bit 9, the busy flag in bit 8 and the word address in bits 6:0. The word address is bank number times 8 plus word index (0..7). A plain control write stores only the unlock and address fields. Bits 9, 8 and 7 ignore writes.
- R3: A write to the set alias ORs the unlock and address fields into the register. A write to the clear alias clears every unlock or address bit that is 1 in the written data. A 1 in bit 9 of a clear-alias write clears the error flag.
- R4: The timing register stores a read-strobe count in bits 21:16, a relax count in bits 15:12 and a program-strobe count in bits 11:0. All other bits read 0.
- R5: Writing 1 to bit 0 of the read command register while idle starts a sense of the addressed word. Once busy falls, the read-data register holds that word.
- R6: With relax count r and strobe count s (the read count for a sense, the program count for a program), busy is high for exactly 2(r+1) + max(s+1-2(r+1), 1) cycles, starting at the clock edge that takes the starting write.
- R7: A write to the write-data register while idle, with the unlock field equal to 0x3E77, starts a program. The addressed word becomes its old value OR the written data.
- R8: The unlock field reads 0 once a program sequence ends, so a second program needs a new unlock.
- R9: A write-data write without the correct unlock value sets the error flag, does not start a sequence, and leaves the fuse array unchanged.
- R10: A sense or program request while busy sets the error flag and starts nothing. The running sequence still ends normally.
- R11: The error flag stays set through unrelated writes until it is cleared as R3 describes.
- R12: While busy, writes to the control, set alias, clear alias and timing registers do not change the unlock, address or timing fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` (combinational) |

## Verification
A sequencer whose phase counter is wrong shows up as a busy flag that is high for the wrong number of cycles. The bench counts these cycles exactly, so the fault is reported on the first sense or program. A fuse word written in the wrong cycle, or at the wrong address, shows up in the next sense as a value other than the OR of everything programmed there. An unlock field that is not wiped, or an error flag that is not sticky, can be seen in the control register right after the operation that should have changed it.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  localparam int DW     = 32;
  localparam int AW     = 7;
  localparam int KEY_W  = 16;
  localparam int RLX_W  = 4;
  localparam int SRD_W  = 6;
  localparam int SPG_W  = 12;
  localparam int CNT_W  = SPG_W + 1;
  localparam int REG_AW = 3;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_CSET = 3'd1;
  localparam logic [REG_AW-1:0] REG_CCLR = 3'd2;
  localparam logic [REG_AW-1:0] REG_TIME = 3'd3;
  localparam logic [REG_AW-1:0] REG_RCMD = 3'd4;
  localparam logic [REG_AW-1:0] REG_RDAT = 3'd5;
  localparam logic [REG_AW-1:0] REG_WDAT = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_STROBE, ST_POST} seq_st_e;

  // Strobe phase length: total strobe count minus both relax intervals, at least one cycle.
  function automatic logic [CNT_W-1:0] strobe_cycles(input logic [RLX_W-1:0] relax,
                                                     input logic [SPG_W-1:0] strobe);
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] frame;
    total = CNT_W'(strobe) + CNT_W'(1);
    frame = (CNT_W'(relax) + CNT_W'(1)) << 1;
    return (total > frame) ? total - frame : CNT_W'(1);
  endfunction
endpackage

// File: rtl/otp_seq_array.sv
module otp_seq_array
  import otp_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rd_word = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= mem[addr] | wr_val;
    end
  end

  // R7
  only_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (($past(rd_word) & ~rd_word) == '0));
endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
  import otp_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_prog,
  input  logic [RLX_W-1:0] relax,
  input  logic [SRD_W-1:0] rd_strobe,
  input  logic [SPG_W-1:0] pg_strobe,
  output logic             busy,
  output logic             fire,
  output logic             op_prog
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slen_q;
  logic [RLX_W-1:0] relax_q;
  logic [CNT_W-1:0] slen_sel;
  logic             cnt_zero;

  assign slen_sel = strobe_cycles(relax, start_prog ? pg_strobe : SPG_W'(rd_strobe));
  assign cnt_zero = (cnt_q == '0);
  assign busy     = (st_q != ST_IDLE);
  assign fire     = (st_q == ST_STROBE) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      slen_q  <= '0;
      relax_q <= '0;
      op_prog <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_PRE;
          cnt_q   <= CNT_W'(relax);
          relax_q <= relax;
          slen_q  <= slen_sel;
          op_prog <= start_prog;
        end
        ST_PRE: if (cnt_zero) begin
          st_q  <= ST_STROBE;
          cnt_q <= slen_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_STROBE: if (cnt_zero) begin
          st_q  <= ST_POST;
          cnt_q <= CNT_W'(relax_q);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_POST: if (cnt_zero) st_q <= ST_IDLE;
                 else cnt_q <= cnt_q - CNT_W'(1);
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R6
  post_relax_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy && !fire));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_prog));
endmodule

// File: rtl/otp_seq_regs.sv
module otp_seq_regs
  import otp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              fire,
  input  logic              op_prog,
  input  logic [DW-1:0]     fuse_word,
  output logic [AW-1:0]     fuse_addr,
  output logic [DW-1:0]     prog_val,
  output logic [RLX_W-1:0]  relax,
  output logic [SRD_W-1:0]  rd_strobe,
  output logic [SPG_W-1:0]  pg_strobe,
  output logic              start,
  output logic              start_prog
);
  localparam int ERR_BIT  = 9;
  localparam int BUSY_BIT = 8;

  logic [KEY_W-1:0] unlock_q;
  logic             err_q;
  logic [DW-1:0]    rdat_q;
  logic             key_ok;
  logic             req_sense;
  logic             req_prog;
  logic             refuse;
  logic             err_clr;
  logic [DW-1:0]    ctrl_view;
  logic [DW-1:0]    time_view;

  assign key_ok     = (unlock_q == UNLOCK_KEY);
  assign req_sense  = bus_we && (bus_addr == REG_RCMD) && bus_wdata[0];
  assign req_prog   = bus_we && (bus_addr == REG_WDAT);
  assign start_prog = req_prog && !busy && key_ok;
  assign start      = (req_sense && !busy) || start_prog;
  assign refuse     = (req_sense && busy) || (req_prog && (busy || !key_ok));
  assign err_clr    = bus_we && (bus_addr == REG_CCLR) && bus_wdata[ERR_BIT];

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[31:16]    = unlock_q;
    ctrl_view[ERR_BIT]  = err_q;
    ctrl_view[BUSY_BIT] = busy;
    ctrl_view[AW-1:0]   = fuse_addr;
    time_view           = '0;
    time_view[21:16]    = rd_strobe;
    time_view[15:12]    = relax;
    time_view[11:0]     = pg_strobe;
    case (bus_addr)
      REG_CTRL, REG_CSET, REG_CCLR: bus_rdata = ctrl_view;
      REG_TIME:                     bus_rdata = time_view;
      REG_RDAT:                     bus_rdata = rdat_q;
      default:                      bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q  <= '0;
      fuse_addr <= '0;
      err_q     <= 1'b0;
      rdat_q    <= '0;
      prog_val  <= '0;
      relax     <= '0;
      rd_strobe <= '0;
      pg_strobe <= '0;
    end else begin
      if (bus_we && !busy) begin
        case (bus_addr)
          REG_CTRL: begin
            unlock_q  <= bus_wdata[31:16];
            fuse_addr <= bus_wdata[AW-1:0];
          end
          REG_CSET: begin
            unlock_q  <= unlock_q | bus_wdata[31:16];
            fuse_addr <= fuse_addr | bus_wdata[AW-1:0];
          end
          REG_CCLR: begin
            unlock_q  <= unlock_q & ~bus_wdata[31:16];
            fuse_addr <= fuse_addr & ~bus_wdata[AW-1:0];
          end
          REG_TIME: begin
            rd_strobe <= bus_wdata[21:16];
            relax     <= bus_wdata[15:12];
            pg_strobe <= bus_wdata[11:0];
          end
          default: ;
        endcase
      end
      if (start_prog) prog_val <= bus_wdata;
      if (fire && op_prog) unlock_q <= '0;
      if (fire && !op_prog) rdat_q <= fuse_word;
      if (refuse) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  // R8
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_prog) |=> (unlock_q == '0));
  // R9
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> err_q);
  // R12
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> ($stable(fuse_addr) && $stable(relax) && $stable(pg_strobe)));
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic [AW-1:0]    fuse_addr;
  logic [DW-1:0]    fuse_word;
  logic [DW-1:0]    prog_val;
  logic [RLX_W-1:0] relax;
  logic [SRD_W-1:0] rd_strobe;
  logic [SPG_W-1:0] pg_strobe;
  logic             start;
  logic             start_prog;
  logic             busy;
  logic             fire;
  logic             op_prog;

  otp_seq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .fire       (fire),
    .op_prog    (op_prog),
    .fuse_word  (fuse_word),
    .fuse_addr  (fuse_addr),
    .prog_val   (prog_val),
    .relax      (relax),
    .rd_strobe  (rd_strobe),
    .pg_strobe  (pg_strobe),
    .start      (start),
    .start_prog (start_prog)
  );

  otp_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_prog (start_prog),
    .relax      (relax),
    .rd_strobe  (rd_strobe),
    .pg_strobe  (pg_strobe),
    .busy       (busy),
    .fire       (fire),
    .op_prog    (op_prog)
  );

  otp_seq_array u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (fuse_addr),
    .wr_en   (fire && op_prog),
    .wr_val  (prog_val),
    .rd_word (fuse_word)
  );
endmodule

// File: tb/otp_seq_bench.sv
module otp_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [15:0] KEY = 16'h3E77;

  otp_seq u_otp_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [6:0] word_at(input int bank, input int idx);
    return 7'((bank * 8) + idx);
  endfunction

  function automatic int busy_len(input int r, input int s);
    int edge_part = 2 * (r + 1);
    int mid = s + 1 - edge_part;
    if (mid < 1) mid = 1;
    return edge_part + mid;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // Counts busy cycles starting at the negedge that follows the starting write.
  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    rd(3'd0, c);
    while (c[8] && n < 10000) begin
      n++;
      @(negedge clk);
      rd(3'd0, c);
    end
  endtask

  task automatic sense(output logic [31:0] v, output int n);
    wr(3'd4, 32'd1);
    wait_idle(n);
    rd(3'd5, v);
  endtask

  task automatic t_reset();
    logic [31:0] v; int n;
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd3, v); check("R1 timing", v, 32'h0);
    rd(3'd5, v); check("R1 rdata", v, 32'h0);
    wr(3'd0, {16'h0, 9'h0, word_at(15, 7)});
    sense(v, n); check("R1 fuse zero", v, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_03FF);
    rd(3'd0, v); check("R2 ctrl fields", v, 32'hFFFF_007F);
    wr(3'd0, {16'h0, 9'h0, word_at(2, 3)});
    rd(3'd0, v); check("R2 bank/word addr", v, 32'h0000_0013);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0001_0005);
    rd(3'd0, v); check("R3 set alias", v, 32'h0001_0005);
    wr(3'd1, 32'h0002_0010);
    rd(3'd1, v); check("R3 set alias or", v, 32'h0003_0015);
    wr(3'd2, 32'h0001_0001);
    rd(3'd2, v); check("R3 clear alias", v, 32'h0002_0014);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R4 timing mask", v, 32'h003F_FFFF);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_sense_len();
    logic [31:0] v; int n;
    wr(3'd0, {16'h0, 9'h0, word_at(2, 3)});
    sense(v, n);
    check("R6 zero timing length", 32'(n), 32'(busy_len(0, 0)));
    check("R5 sense data", v, 32'h0);
    wr(3'd3, {10'h0, 6'd10, 4'd2, 12'd5});
    sense(v, n);
    check("R6 read strobe length", 32'(n), 32'(busy_len(2, 10)));
  endtask

  task automatic t_program();
    logic [31:0] v; int n;
    wr(3'd3, {10'h0, 6'd10, 4'd1, 12'd20});
    wr(3'd0, {KEY, 9'h0, word_at(2, 3)});
    wr(3'd6, 32'h0000_F00F);
    wait_idle(n);
    check("R6 program length", 32'(n), 32'(busy_len(1, 20)));
    rd(3'd0, v); check("R8 unlock wiped", v, 32'h0000_0013);
    sense(v, n);
    check("R6 sense length", 32'(n), 32'(busy_len(1, 10)));
    check("R7 programmed value", v, 32'h0000_F00F);
    wr(3'd0, {KEY, 9'h0, word_at(2, 3)});
    wr(3'd6, 32'h00FF_00F0);
    wait_idle(n);
    sense(v, n); check("R7 bits OR", v, 32'h00FF_F0FF);
    wr(3'd0, {16'h0, 9'h0, word_at(2, 4)});
    sense(v, n); check("R7 neighbour untouched", v, 32'h0);
  endtask

  task automatic t_nokey();
    logic [31:0] v; int n;
    wr(3'd0, {16'h0, 9'h0, word_at(2, 3)});
    wr(3'd6, 32'h0F00_0000);
    rd(3'd0, v); check("R9 refused, error set, not busy", v, 32'h0000_0213);
    wr(3'd1, 32'h0000_0000);
    rd(3'd0, v); check("R11 error sticky", v[9], 32'h1);
    sense(v, n); check("R9 array unchanged", v, 32'h00FF_F0FF);
    wr(3'd0, {16'h1234, 9'h0, word_at(2, 3)});
    wr(3'd6, 32'hF000_0000);
    sense(v, n); check("R9 wrong key no change", v, 32'h00FF_F0FF);
    wr(3'd2, 32'h0000_0200);
    rd(3'd0, v); check("R11 error cleared", v[9], 32'h0);
  endtask

  task automatic t_relock();
    logic [31:0] v; int n;
    wr(3'd0, {KEY, 9'h0, word_at(1, 1)});
    wr(3'd6, 32'h0000_0001);
    wait_idle(n);
    wr(3'd6, 32'h8000_0000);
    rd(3'd0, v); check("R8 second program refused", v[9], 32'h1);
    sense(v, n); check("R8 second program no effect", v, 32'h0000_0001);
    wr(3'd2, 32'h0000_0200);
  endtask

  task automatic t_busy();
    logic [31:0] v; int n;
    wr(3'd3, {10'h0, 6'd40, 4'd3, 12'd8});
    wr(3'd0, {KEY, 9'h0, word_at(2, 3)});
    wr(3'd4, 32'd1);
    wr(3'd4, 32'd1);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0000_0005);
    wr(3'd2, 32'hFFFF_007F);
    wr(3'd3, 32'h0);
    rd(3'd0, v); check("R10 still busy with error", v[9:8], 32'h3);
    wait_idle(n);
    @(negedge clk);
    rd(3'd0, v); check("R12 ctrl frozen, R10 no restart", v, {KEY, 16'h0213});
    rd(3'd3, v); check("R12 timing frozen", v, {10'h0, 6'd40, 4'd3, 12'd8});
    rd(3'd5, v); check("R10 running sense completed", v, 32'h00FF_F0FF);
    wr(3'd0, {16'h0, 9'h0, word_at(2, 3)});
    wr(3'd3, 32'h0);
    sense(v, n); check("R10 busy program not applied", v, 32'h00FF_F0FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_alias();
    t_timing();
    t_sense_len();
    t_program();
    t_nokey();
    t_relock();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule